// File: doc/BRIEF.md
# Two-Thread Core Mode Controller

This block keeps track of the operating mode of a core that runs two hardware threads. It takes single-cycle pulses that say a thread has executed a halt, and single-cycle pulses that say an interrupt was delivered to a thread. From these it keeps a two-bit record of which threads are running. That record selects one of four modes: both threads running, only thread 0 running, only thread 1 running, or a low-power state with no thread running.

When exactly one thread runs, the block tells the shared buffers to merge their per-thread partitions into one pool for that thread. A mode change alters the partitioning, so the block never commits one at once. It first raises a drain request and waits until the buffers return a drained acknowledge. Only then does it update the mode, the thread-active flags, the merge signal and the low-power request.

Halts and interrupts that arrive while a drain is in progress are not dropped. They are folded into the pending target, and the acknowledge commits the target as updated by the events of that same cycle.

The controller has two states. SETTLED is where the mode is stable. DRAINING is where a new target waits for the acknowledge. There are three transitions:
- SETTLED to DRAINING, when an event changes the running set.
- DRAINING to DRAINING, on each cycle without an acknowledge, when later events update the target.
- DRAINING to SETTLED, on the acknowledge, when the target is committed.

Top module: `thread_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (both threads running), `active_o` is 2'b11, and `recombine_o`, `low_power_o` and `drain_req_o` are all 0.
- R2: With both threads running, a halt from thread 0 alone leads to `mode_o` 2'b10 (only thread 1 running). A halt from thread 1 alone leads to `mode_o` 2'b01 (only thread 0 running).
- R3: A halt from the one running thread leads to `mode_o` 2'b11 (low power). Halts from both threads in the same cycle, while both run, also go straight to low power.
- R4: An interrupt to a halted thread while the other thread runs returns the core to 2'b00. An interrupt to a running thread changes nothing and raises no drain request.
- R5: In low power, an interrupt to one thread wakes the core into the single-thread mode of that thread. Interrupts to both threads in the same cycle wake it into 2'b00.
- R6: A halt pulse from a thread that is not running is ignored: there is no drain request and the outputs are unchanged.
- R7: An event that changes the running set raises `drain_req_o` on the next cycle. `drain_req_o` stays high, and all mode outputs stay unchanged, until the cycle in which `drain_ack_i` is sampled high. In the following cycle the new mode shows and `drain_req_o` is 0.
- R8: Events that arrive while draining, including in the acknowledge cycle, update the pending target. The commit applies the updated target, even when that target equals the old mode.
- R9: A halt and an interrupt to the same thread in the same cycle leave that thread running.
- R10: `active_o` bit n is 1 when thread n runs. `recombine_o` is 1 exactly when one thread runs. `low_power_o` is 1 exactly in mode 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 2 | Per-thread halt-executed pulse, bit n for thread n |
| intr_i | input | 2 | Per-thread interrupt-delivered pulse |
| drain_ack_i | input | 1 | Shared buffers report they are drained |
| mode_o | output | 2 | Current mode: 00 both, 01 thread 0 only, 10 thread 1 only, 11 low power |
| active_o | output | 2 | Per-thread running flags |
| recombine_o | output | 1 | Merge partitioned buffers for the single running thread |
| low_power_o | output | 1 | Request for the low-power state |
| drain_req_o | output | 1 | Request to drain the buffers before repartitioning |

## Verification
The bench sweeps every starting mode against all sixteen combinations of halt and interrupt pulses. It varies how long the acknowledge is delayed, so that an early commit is caught as a mode that changes before the acknowledge. A design that did not mask halts from threads that are not running would start spurious drains or fall into low power. A design that ordered a same-thread halt and interrupt the other way would lose a running thread. Directed cases send events during a drain and in the acknowledge cycle. A controller that froze its target at drain start would commit a stale mode, or would miss a return to the original mode.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    localparam int unsigned THREADS = 2;

    typedef enum logic [1:0] {
        MODE_BOTH  = 2'b00,
        MODE_ONLY0 = 2'b01,
        MODE_ONLY1 = 2'b10,
        MODE_SLEEP = 2'b11
    } core_mode_e;

    typedef enum logic {
        FSM_SETTLED  = 1'b0,
        FSM_DRAINING = 1'b1
    } fsm_state_e;

endpackage

// File: rtl/tmc_event_merge.sv
module tmc_event_merge #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] base_i,
    input  logic [N-1:0] halt_i,
    input  logic [N-1:0] intr_i,
    output logic [N-1:0] next_o
);

    // A halt clears a running thread first, then an interrupt sets its thread.
    // A halt of a thread that is not running has nothing to clear.
    for (genvar g = 0; g < N; g++) begin : g_thr
        assign next_o[g] = (base_i[g] & ~halt_i[g]) | intr_i[g];
    end

endmodule

// File: rtl/tmc_mode_decode.sv
module tmc_mode_decode
    import tmc_pkg::*;
(
    input  logic [THREADS-1:0] run_i,
    output core_mode_e         mode_o,
    output logic               recombine_o,
    output logic               low_power_o
);

    always_comb begin
        mode_o      = MODE_BOTH;
        recombine_o = 1'b0;
        low_power_o = 1'b0;
        unique case (run_i)
            2'b11: begin
                mode_o = MODE_BOTH;
            end
            2'b01: begin
                mode_o      = MODE_ONLY0;
                recombine_o = 1'b1;
            end
            2'b10: begin
                mode_o      = MODE_ONLY1;
                recombine_o = 1'b1;
            end
            2'b00: begin
                mode_o      = MODE_SLEEP;
                low_power_o = 1'b1;
            end
            default: begin
                mode_o = MODE_BOTH;
            end
        endcase
    end

endmodule

// File: rtl/thread_mode_ctrl.sv
module thread_mode_ctrl
    import tmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] halt_i,
    input  logic [1:0] intr_i,
    input  logic       drain_ack_i,
    output logic [1:0] mode_o,
    output logic [1:0] active_o,
    output logic       recombine_o,
    output logic       low_power_o,
    output logic       drain_req_o
);

    fsm_state_e         state_q, state_d;
    logic [THREADS-1:0] run_q, run_d;
    logic [THREADS-1:0] pend_q, pend_d;
    logic [THREADS-1:0] from_run, from_pend;
    core_mode_e         mode_w;
    logic               recomb_w, sleep_w;

    tmc_event_merge #(.N(THREADS)) u_merge_run (
        .base_i (run_q),
        .halt_i (halt_i),
        .intr_i (intr_i),
        .next_o (from_run)
    );

    tmc_event_merge #(.N(THREADS)) u_merge_pend (
        .base_i (pend_q),
        .halt_i (halt_i),
        .intr_i (intr_i),
        .next_o (from_pend)
    );

    tmc_mode_decode u_decode (
        .run_i       (run_q),
        .mode_o      (mode_w),
        .recombine_o (recomb_w),
        .low_power_o (sleep_w)
    );

    // Transition logic
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        pend_d  = pend_q;
        unique case (state_q)
            FSM_SETTLED: begin
                if (from_run != run_q) begin
                    state_d = FSM_DRAINING;
                    pend_d  = from_run;
                end
            end
            FSM_DRAINING: begin
                pend_d = from_pend;
                if (drain_ack_i) begin
                    run_d   = from_pend;
                    state_d = FSM_SETTLED;
                end
            end
            default: state_d = FSM_SETTLED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FSM_SETTLED;
            run_q   <= 2'b11;
            pend_q  <= 2'b11;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            pend_q  <= pend_d;
        end
    end

    // Outputs
    always_comb begin
        mode_o      = mode_w;
        active_o    = run_q;
        recombine_o = recomb_w;
        low_power_o = sleep_w;
        drain_req_o = (state_q == FSM_DRAINING);
    end

    AST_CHANGE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_o) |-> $past(drain_req_o && drain_ack_i)); // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req_o && !drain_ack_i) |=> (drain_req_o && $stable(mode_o))); // R7
    AST_RECOMBINE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        recombine_o |-> ($countones(active_o) == 1)); // R10
    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        low_power_o |-> (active_o == 2'b00 && !recombine_o)); // R10
    AST_IDLE_HALT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_req_o && intr_i == 2'b00 && (halt_i & active_o) == 2'b00)
        |=> !drain_req_o); // R6

endmodule

// File: tb/thread_mode_ctrl_bench.sv
module thread_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] halt_i = 2'b00;
    logic [1:0] intr_i = 2'b00;
    logic       drain_ack_i = 1'b0;
    logic [1:0] mode_o, active_o;
    logic       recombine_o, low_power_o, drain_req_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    thread_mode_ctrl u_thread_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .intr_i(intr_i),
        .drain_ack_i(drain_ack_i), .mode_o(mode_o), .active_o(active_o),
        .recombine_o(recombine_o), .low_power_o(low_power_o),
        .drain_req_o(drain_req_o)
    );

    function automatic logic [1:0] mode_of(input logic [1:0] run);
        case (run)
            2'b11:   return 2'b00;
            2'b01:   return 2'b01;
            2'b10:   return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] next_run(input logic [1:0] run, input logic [1:0] h, input logic [1:0] i);
        return (run & ~h) | i;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [1:0] run);
        logic [5:0] exp;
        exp = {mode_of(run), run, ($countones(run) == 1), (run == 2'b00)};
        chk(req, {2'b00, mode_o, active_o, recombine_o, low_power_o}, {2'b00, exp});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; halt_i = 2'b00; intr_i = 2'b00; drain_ack_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pulse events for one cycle; drive the drain handshake with w wait cycles.
    task automatic event_hs(input string req, input logic [1:0] cur, input logic [1:0] h,
                            input logic [1:0] i, input int w);
        logic [1:0] exp;
        exp = next_run(cur, h, i);
        @(negedge clk); halt_i = h; intr_i = i;
        @(negedge clk); halt_i = 2'b00; intr_i = 2'b00;
        if (exp == cur) begin
            chk(req, {7'd0, drain_req_o}, 8'd0);
            check_out(req, cur);
        end else begin
            chk("R7", {7'd0, drain_req_o}, 8'd1);
            check_out("R7", cur);
            for (int k = 0; k < w; k++) begin
                @(negedge clk);
                chk("R7", {7'd0, drain_req_o}, 8'd1);
                check_out("R7", cur);
            end
            drain_ack_i = 1'b1;
            @(negedge clk); drain_ack_i = 1'b0;
            chk("R7", {7'd0, drain_req_o}, 8'd0);
            check_out(req, exp);
        end
    endtask

    function automatic string tag_for(input logic [1:0] s, input logic [1:0] h, input logic [1:0] i);
        logic [1:0] e;
        e = next_run(s, h, i);
        if ((h & i & s) != 2'b00) return "R9";
        if ((h & ~s) != 2'b00 && e == s) return "R6";
        if (s == 2'b00) return "R5";
        if (e == 2'b00) return "R3";
        if (s == 2'b11 && e != 2'b11) return "R2";
        return "R4";
    endfunction

    initial begin
        do_reset();
        @(negedge clk);
        check_out("R1", 2'b11);
        chk("R1", {7'd0, drain_req_o}, 8'd0);

        // Sweep: every start set x every halt/interrupt pattern
        for (int s = 0; s < 4; s++) begin
            for (int h = 0; h < 4; h++) begin
                for (int i = 0; i < 4; i++) begin
                    do_reset();
                    if (s != 3) begin
                        event_hs("R10", 2'b11, ~s[1:0], 2'b00, 0);
                    end
                    event_hs(tag_for(s[1:0], h[1:0], i[1:0]), s[1:0], h[1:0], i[1:0], (h + i) % 3);
                end
            end
        end

        // R8: interrupt during drain returns target to original mode
        do_reset();
        @(negedge clk); halt_i = 2'b01;
        @(negedge clk); halt_i = 2'b00; intr_i = 2'b01;
        @(negedge clk); intr_i = 2'b00;
        chk("R8", {7'd0, drain_req_o}, 8'd1);
        drain_ack_i = 1'b1;
        @(negedge clk); drain_ack_i = 1'b0;
        check_out("R8", 2'b11);
        chk("R8", {7'd0, drain_req_o}, 8'd0);

        // R8: halt in the acknowledge cycle is folded into the commit
        do_reset();
        @(negedge clk); halt_i = 2'b01;
        @(negedge clk); halt_i = 2'b10; drain_ack_i = 1'b1;
        @(negedge clk); halt_i = 2'b00; drain_ack_i = 1'b0;
        check_out("R8", 2'b00);

        // R8: from thread-0-only, drain to sleep then both interrupts wake to both
        do_reset();
        event_hs("R2", 2'b11, 2'b10, 2'b00, 1);
        @(negedge clk); halt_i = 2'b01;
        @(negedge clk); halt_i = 2'b00; intr_i = 2'b11;
        @(negedge clk); intr_i = 2'b00;
        check_out("R8", 2'b01);
        drain_ack_i = 1'b1;
        @(negedge clk); drain_ack_i = 1'b0;
        check_out("R8", 2'b11);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule